// File: doc/BRIEF.md
# Statically Routed Crossbar Interconnect

This block is the routing fabric of an exposed-datapath processor. Every datapath unit output is a source and every unit input is a destination. Each destination has its own switchbox, a multiplexer that selects one source. The choice comes from a packed control vector that the instruction stream supplies fresh every cycle. No hazard detection or forwarding logic sits inside the fabric: the code generator decides every route.

A compile-time path mask can remove source-to-destination links that an application domain never uses. This gives a pruned fabric with fewer gates. A select that names a removed link, or names a source index that does not exist, drives zero on that destination and raises its route-error flag.

The fabric is purely combinational. There is no stream interface, so no valid/ready back-pressure applies. The default configuration has 7 sources, 8 destinations and 32-bit data, which gives a 24-bit control vector.

Top module: `xbar_route_fabric`

## Requirements
- R1: In the same cycle, every destination may select any source, independently of the selects of the other destinations.
- R2: Each select is W bits wide, where W is the ceiling of log2 of the source count (minimum 1). Destination i takes `ctrl_word[i*W +: W]`, with destination 0 in the least significant bits. The default width is 8 x 3 = 24 bits.
- R3: Source s is presented on `src_bus[s*DW +: DW]`. Destination d is driven on `dst_bus[d*DW +: DW]`. When the select of destination d has a value s below the source count and the path is enabled, destination d carries source s.
- R4: When a select value is at or above the source count, that destination drives all zeros and its `route_err` bit is 1.
- R5: Path-mask bit `d*N_SRC + s` enables the link from source s to destination d. When the bit is 0 and destination d selects s, the destination drives zero and its `route_err` bit is 1.
- R6: A pruned fabric routes every select that is still legal in it exactly as the full fabric does.
- R7: A legal select clears that destination's `route_err` bit.
- R8: The fabric holds no state. The outputs are a function of the present inputs only and follow them in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ctrl_word | input | N_DST*W (24) | Packed per-destination source selects |
| src_bus | input | N_SRC*DW (224) | Concatenated source outputs |
| dst_bus | output | N_DST*DW (256) | Concatenated destination inputs |
| route_err | output | N_DST (8) | Per-destination illegal-route flag |

## Verification
A decode fault in a switchbox shows up immediately as a wrong word on that destination's slice. Because every source carries a distinct value, the bench can name the source that was wrongly chosen. A mask or range fault shows up as a non-zero word, or a missing error flag, on a pruned or out-of-range select in that same cycle. Rotating the selects across all destinations at once also exposes a field mis-slicing: one destination would follow its neighbour's select.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int BASE_SRC = 7;
  localparam int BASE_DST = 8;
  localparam int BASE_DW  = 32;

  function automatic int sel_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/xbar_sel_decode.sv
module xbar_sel_decode #(
  parameter int N_SRC = 7,
  parameter int SEL_W = 3,
  parameter logic [N_SRC-1:0] PATH_EN = '1
) (
  input  logic [SEL_W-1:0] sel,
  output logic [N_SRC-1:0] hit,
  output logic             illegal
);
  always_comb begin
    hit = '0;
    for (int s = 0; s < N_SRC; s++) begin
      if (sel == SEL_W'(s)) hit[s] = PATH_EN[s];
    end
    illegal = ~|hit;
  end

  always_comb begin
    // R3
    hit_onehot_chk: assert ($onehot0(hit));
    // R4
    range_flag_chk: assert (!(32'(sel) >= N_SRC) || illegal);
  end
endmodule

// File: rtl/xbar_switchbox.sv
module xbar_switchbox #(
  parameter int N_SRC = 7,
  parameter int DW    = 32
) (
  input  logic [N_SRC*DW-1:0] src_flat,
  input  logic [N_SRC-1:0]    hit,
  output logic [DW-1:0]       dout
);
  always_comb begin
    dout = '0;
    for (int s = 0; s < N_SRC; s++) begin
      dout = dout | (src_flat[s*DW +: DW] & {DW{hit[s]}});
    end
  end
endmodule

// File: rtl/xbar_route_fabric.sv
module xbar_route_fabric #(
  parameter int N_SRC = xbar_pkg::BASE_SRC,
  parameter int N_DST = xbar_pkg::BASE_DST,
  parameter int DW    = xbar_pkg::BASE_DW,
  parameter logic [N_DST*N_SRC-1:0] PATH_MASK = '1,
  localparam int SEL_W  = xbar_pkg::sel_width(N_SRC),
  localparam int CTRL_W = N_DST * SEL_W
) (
  input  logic [CTRL_W-1:0]   ctrl_word,
  input  logic [N_SRC*DW-1:0] src_bus,
  output logic [N_DST*DW-1:0] dst_bus,
  output logic [N_DST-1:0]    route_err
);
  for (genvar d = 0; d < N_DST; d++) begin : g_dst
    logic [SEL_W-1:0] sel_d;
    logic [N_SRC-1:0] hit_d;
    logic [DW-1:0]    ref_d;
    logic             ref_ok;

    assign sel_d = ctrl_word[d*SEL_W +: SEL_W];

    xbar_sel_decode #(
      .N_SRC  (N_SRC),
      .SEL_W  (SEL_W),
      .PATH_EN(PATH_MASK[d*N_SRC +: N_SRC])
    ) u_dec (
      .sel    (sel_d),
      .hit    (hit_d),
      .illegal(route_err[d])
    );

    xbar_switchbox #(
      .N_SRC(N_SRC),
      .DW   (DW)
    ) u_box (
      .src_flat(src_bus),
      .hit     (hit_d),
      .dout    (dst_bus[d*DW +: DW])
    );

    // independent reference route for cross-checking the decode + mux pair
    always_comb begin
      ref_d  = '0;
      ref_ok = 1'b0;
      for (int s = 0; s < N_SRC; s++) begin
        if (32'(sel_d) == s && PATH_MASK[d*N_SRC + s]) begin
          ref_d  = src_bus[s*DW +: DW];
          ref_ok = 1'b1;
        end
      end
    end

    always_comb begin
      // R3
      route_match_chk: assert (!ref_ok || dst_bus[d*DW +: DW] == ref_d);
      // R4
      zero_on_err_chk: assert (!route_err[d] || dst_bus[d*DW +: DW] == '0);
      // R5
      pruned_block_chk: assert (ref_ok || route_err[d]);
      // R7
      legal_clear_chk: assert (!ref_ok || !route_err[d]);
    end
  end
endmodule

// File: tb/xbar_route_fabric_tb.sv
module xbar_route_fabric_tb_top;
  localparam int NS = 7;
  localparam int ND = 8;
  localparam int DW = 32;
  localparam int SW = 3;

  function automatic logic [ND*NS-1:0] prune_mask();
    logic [ND*NS-1:0] m;
    for (int d = 0; d < ND; d++)
      for (int s = 0; s < NS; s++)
        m[d*NS + s] = ((d*3 + s) % 4) != 1;
    return m;
  endfunction
  localparam logic [ND*NS-1:0] PMASK = prune_mask();

  logic clk = 0;
  always #5 clk = ~clk;

  logic [ND*SW-1:0] ctrl;
  logic [NS*DW-1:0] src;
  logic [ND*DW-1:0] dst_f, dst_p;
  logic [ND-1:0]    err_f, err_p;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  xbar_route_fabric dut_i (
    .ctrl_word(ctrl), .src_bus(src), .dst_bus(dst_f), .route_err(err_f));

  xbar_route_fabric #(.PATH_MASK(PMASK)) dut_pr (
    .ctrl_word(ctrl), .src_bus(src), .dst_bus(dst_p), .route_err(err_p));

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] src_val(input int set, input int s);
    return (set == 0) ? (32'hA500_0000 | 32'(s * 32'h0101 + 1))
                      : ~(32'h3C00_0000 | 32'(s * 32'h1010 + 7));
  endfunction

  task automatic apply_and_check(input int set, input int rot, input string tag);
    @(posedge clk);
    for (int s = 0; s < NS; s++) src[s*DW +: DW] = src_val(set, s);
    for (int d = 0; d < ND; d++) ctrl[d*SW +: SW] = SW'((rot + d) % 8);
    @(negedge clk);
    for (int d = 0; d < ND; d++) begin
      int sel = (rot + d) % 8;
      logic [DW-1:0] ef, ep;
      logic xf, xp;
      ef = (sel < NS) ? src_val(set, sel) : '0;
      xf = (sel >= NS);
      xp = xf || !PMASK[d*NS + sel % NS];
      ep = xp ? '0 : ef;
      // R1 R2 R3 R4 R7: full fabric; R5 R6: pruned fabric
      check({tag, " R3/R4 full data"}, dst_f[d*DW +: DW], ef);
      check({tag, " R7/R4 full err"}, 32'(err_f[d]), 32'(xf));
      check({tag, " R5/R6 pruned data"}, dst_p[d*DW +: DW], ep);
      check({tag, " R5 pruned err"}, 32'(err_p[d]), 32'(xp));
    end
  endtask

  initial begin
    ctrl = '0;
    src  = '0;
    for (int s = 0; s < NS; s++) src[s*DW +: DW] = src_val(0, s);
    @(negedge clk);
    // R8 initial state: all selects zero -> every destination shows source 0
    for (int d = 0; d < ND; d++)
      check("R8 idle route", dst_f[d*DW +: DW], src_val(0, 0));
    for (int set = 0; set < 2; set++)
      for (int rot = 0; rot < 8; rot++)
        apply_and_check(set, rot, "R1 sweep");
    // R8: change sources only, outputs follow in the same cycle
    @(posedge clk);
    ctrl = '0;
    src[0 +: DW] = 32'hDEAD_BEEF;
    @(negedge clk);
    check("R8 follow", dst_f[0 +: DW], 32'hDEAD_BEEF);
    // R2: only destination 7's field set to 5, others 0
    @(posedge clk);
    ctrl = '0;
    ctrl[7*SW +: SW] = 3'd5;
    for (int s = 0; s < NS; s++) src[s*DW +: DW] = src_val(1, s);
    @(negedge clk);
    check("R2 top field", dst_f[7*DW +: DW], src_val(1, 5));
    check("R2 low field", dst_f[6*DW +: DW], src_val(1, 0));
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=%0d exp<=20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule